// File: doc/BRIEF.md
# Alternate-Byte Peripheral Transfer Sequencer

This block moves a 16-bit or 32-bit register value to or from a byte-wide peripheral that is wired to only one byte lane of a 16-bit bus. Such a peripheral occupies every second byte address. The block therefore splits the register into bytes and issues one single-byte bus cycle per byte, stepping the address by two each time. On a read it rebuilds the register value from the bytes it collects.

A transfer is started by a one-cycle pulse. The pulse carries the direction, the size, the base address register value, a signed 16-bit displacement, the value to send and the current value of the destination register. The block drives a simple bus master with an acknowledge handshake. One instruction-fetch marker cycle comes before the data bytes and one comes after them. Then a one-cycle done pulse is given, and on reads the assembled value is presented.

Top module: `altbyte_xfer`

## Requirements
- R1: The first data byte cycle uses the address base + sign-extended displacement, computed modulo 2^32. For example, base 0x00001000 with displacement 0xFFFE gives 0x00000FFE.
- R2: Each following data byte cycle uses the previous data address plus 2. Every data cycle selects exactly one byte lane. bus_bsel_o is 2'b10 (upper lane) when the address is even and 2'b01 (lower lane) when it is odd.
- R3: A long transfer (size_long_i=1) makes four data byte cycles. A word transfer (size_long_i=0) makes two.
- R4: On a write (to_mem_i=1), bytes leave most significant first: bits 31:24, 23:16, 15:8, 7:0 for a long, and bits 15:8, 7:0 for a word. bus_we_o is 1 in data cycles.
- R5: A long read places the bytes it receives, in order, at bits 31:24, 23:16, 15:8 and 7:0 of rdata_o. All 32 bits are replaced.
- R6: A word read places its two bytes at bits 15:8 and 7:0 of rdata_o. Bits 31:16 equal bits 31:16 of dest_i as sampled at start.
- R7: Exactly one prefetch cycle (bus_prefetch_o=1, bus_we_o=0, bus_bsel_o=2'b11) comes before the first data byte, and exactly one comes after the last.
- R8: While bus_req_o is high and bus_ack_i is low, the address, write data, write enable and lane select stay constant, and the sequence does not advance.
- R9: done_o is high for exactly one clock, in the cycle after the trailing prefetch cycle is acknowledged. busy_o is low in that cycle.
- R10: A start pulse received while busy_o is high is ignored. The transfer in progress continues unchanged.
- R11: After reset, bus_req_o, busy_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle transfer request |
| to_mem_i | input | 1 | 1 = register to peripheral, 0 = peripheral to register |
| size_long_i | input | 1 | 1 = 32-bit transfer, 0 = 16-bit |
| base_i | input | 32 | Address register value |
| disp_i | input | 16 | Signed displacement |
| src_i | input | 32 | Value to write |
| dest_i | input | 32 | Current destination register value |
| bus_req_o | output | 1 | Bus cycle requested |
| bus_prefetch_o | output | 1 | Current cycle is a prefetch marker |
| bus_we_o | output | 1 | Write cycle |
| bus_addr_o | output | 32 | Byte address |
| bus_bsel_o | output | 2 | Lane select {upper, lower} |
| bus_wdata_o | output | 8 | Write byte |
| bus_ack_i | input | 1 | Cycle acknowledge |
| bus_rdata_i | input | 8 | Read byte, valid with acknowledge |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer complete pulse |
| rdata_o | output | 32 | Assembled read value |

## Verification
The assertions assume that bus_ack_i is raised only while bus_req_o is high. Under that assumption a stall is always a visible hold of the request. The bench's bus responder only ever acknowledges a pending request, and it varies the stall length from zero to two cycles. The responder also assumes that start_i is a single-cycle pulse. Every start the bench issues, including the stray starts injected while busy, lasts exactly one clock.

// File: rtl/altbyte_pkg.sv
package altbyte_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2,
        ST_POST = 2'd3
    } xfer_state_e;

    localparam logic [1:0] LANE_UPPER = 2'b10;
    localparam logic [1:0] LANE_LOWER = 2'b01;
    localparam logic [1:0] LANE_BOTH  = 2'b11;

endpackage

// File: rtl/altbyte_ea.sv
module altbyte_ea #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] ea_o
);
    localparam int EXT_W = ADDR_W - DISP_W;

    always_comb begin
        ea_o = base_i + {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end
endmodule

// File: rtl/altbyte_lane.sv
module altbyte_lane #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         src_i,
    input  logic [DATA_W-1:0]         acc_i,
    input  logic [$clog2(DATA_W/8)-1:0] idx_i,
    input  logic                      lng_i,
    input  logic [7:0]                rbyte_i,
    output logic [7:0]                wbyte_o,
    output logic [DATA_W-1:0]         merged_o
);
    localparam int NB    = DATA_W / 8;
    localparam int IDX_W = $clog2(NB);

    logic [IDX_W-1:0] top_d;
    logic [IDX_W-1:0] pos_d;

    always_comb begin
        top_d = lng_i ? IDX_W'(NB - 1) : IDX_W'(NB / 2 - 1);
        pos_d = top_d - idx_i;
        wbyte_o  = 8'h00;
        merged_o = acc_i;
        for (int b = 0; b < NB; b++) begin
            if (pos_d == IDX_W'(b)) begin
                wbyte_o = src_i[b*8 +: 8];
                merged_o[b*8 +: 8] = rbyte_i;
            end
        end
    end
endmodule

// File: rtl/altbyte_xfer.sv
module altbyte_xfer #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int DATA_W = 32,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              to_mem_i,
    input  logic              size_long_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dest_i,
    output logic              bus_req_o,
    output logic              bus_prefetch_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [1:0]        bus_bsel_o,
    output logic [7:0]        bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [7:0]        bus_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o
);
    import altbyte_pkg::*;

    localparam int NB     = DATA_W / 8;
    localparam int IDX_W  = $clog2(NB);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        xfer_state_e       st;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              lng;
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] acc;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [ADDR_W-1:0] ea_w;
    logic [7:0]        wbyte_w;
    logic [DATA_W-1:0] merged_w;
    logic              last_w;

    altbyte_ea #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_ea (
        .base_i (base_i),
        .disp_i (disp_i),
        .ea_o   (ea_w)
    );

    altbyte_lane #(.DATA_W(DATA_W)) u_lane (
        .src_i    (seq_q.src),
        .acc_i    (seq_q.acc),
        .idx_i    (seq_q.idx),
        .lng_i    (seq_q.lng),
        .rbyte_i  (bus_rdata_i),
        .wbyte_o  (wbyte_w),
        .merged_o (merged_w)
    );

    always_comb begin
        last_w = seq_q.idx == (seq_q.lng ? IDX_W'(NB - 1) : IDX_W'(NB / 2 - 1));
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st   = ST_PRE;
                    seq_d.idx  = '0;
                    seq_d.addr = ea_w;
                    seq_d.wr   = to_mem_i;
                    seq_d.lng  = size_long_i;
                    seq_d.src  = src_i;
                    seq_d.acc  = size_long_i ? '0
                               : {dest_i[DATA_W-1:HALF_W], {HALF_W{1'b0}}};
                end
            end
            ST_PRE: begin
                if (bus_ack_i) seq_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (bus_ack_i) begin
                    if (!seq_q.wr) seq_d.acc = merged_w;
                    seq_d.addr = seq_q.addr + ADDR_W'(STEP);
                    seq_d.idx  = seq_q.idx + 1'b1;
                    if (last_w) begin
                        seq_d.st  = ST_POST;
                        seq_d.idx = '0;
                    end
                end
            end
            ST_POST: begin
                if (bus_ack_i) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        bus_req_o      = seq_q.st != ST_IDLE;
        bus_prefetch_o = (seq_q.st == ST_PRE) || (seq_q.st == ST_POST);
        bus_we_o       = (seq_q.st == ST_DATA) && seq_q.wr;
        bus_addr_o     = seq_q.addr;
        bus_wdata_o    = bus_we_o ? wbyte_w : 8'h00;
        if (seq_q.st == ST_IDLE)  bus_bsel_o = 2'b00;
        else if (bus_prefetch_o)  bus_bsel_o = LANE_BOTH;
        else                      bus_bsel_o = seq_q.addr[0] ? LANE_LOWER : LANE_UPPER;
        busy_o  = seq_q.st != ST_IDLE;
        done_o  = seq_q.done;
        rdata_o = seq_q.acc;
    end

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
            $stable(bus_wdata_o) && $stable(bus_we_o) && $stable(bus_bsel_o)));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_prefetch_o && bus_ack_i && !last_w) |=>
            (bus_addr_o == $past(bus_addr_o) + ADDR_W'(STEP)));

    assert_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_prefetch_o) |-> ($countones(bus_bsel_o) == 1));

    assert_prefetch_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_prefetch_o |-> (!bus_we_o && bus_bsel_o == LANE_BOTH));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

// File: tb/altbyte_xfer_tb.sv
`timescale 1ns/1ps
module altbyte_xfer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        to_mem_i = 1'b0;
    logic        size_long_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] disp_i = '0;
    logic [31:0] src_i = '0;
    logic [31:0] dest_i = '0;
    logic        bus_req_o, bus_prefetch_o, bus_we_o;
    logic [31:0] bus_addr_o;
    logic [1:0]  bus_bsel_o;
    logic [7:0]  bus_wdata_o;
    logic        bus_ack_i = 1'b0;
    logic [7:0]  bus_rdata_i = '0;
    logic        busy_o, done_o;
    logic [31:0] rdata_o;

    int tests = 0;
    int fails = 0;

    altbyte_xfer u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .to_mem_i(to_mem_i),
        .size_long_i(size_long_i), .base_i(base_i), .disp_i(disp_i),
        .src_i(src_i), .dest_i(dest_i), .bus_req_o(bus_req_o),
        .bus_prefetch_o(bus_prefetch_o), .bus_we_o(bus_we_o),
        .bus_addr_o(bus_addr_o), .bus_bsel_o(bus_bsel_o),
        .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i),
        .bus_rdata_i(bus_rdata_i), .busy_o(busy_o), .done_o(done_o),
        .rdata_o(rdata_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5C;
    endfunction

    task automatic run_xfer(input bit wr, input bit lng, input logic [31:0] base,
                            input logic [15:0] disp, input logic [31:0] src,
                            input logic [31:0] dest, input int seed, input bit stray);
        int nb;
        logic [31:0] a0, a, exp_rd;
        logic [7:0] eb;
        nb = lng ? 4 : 2;
        a0 = base + {{16{disp[15]}}, disp};
        exp_rd = lng ? 32'h0 : {dest[31:16], 16'h0};
        @(negedge clk);
        start_i = 1'b1; to_mem_i = wr; size_long_i = lng;
        base_i = base; disp_i = disp; src_i = src; dest_i = dest;
        @(negedge clk);
        start_i = 1'b0;
        base_i = 32'hDEAD_0000; src_i = 32'h1234_5678; dest_i = 32'h0;
        for (int c = 0; c < nb + 2; c++) begin
            automatic bit pre = (c == 0) || (c == nb + 1);
            automatic int k = c - 1;
            automatic int dly = (c + seed) % 3;
            chk(bus_req_o == 1'b1, "R3 request present", 32'(bus_req_o), 32'h1);
            chk(bus_prefetch_o == pre, "R7 prefetch marker", 32'(bus_prefetch_o), 32'(pre));
            if (pre) begin
                chk(bus_bsel_o == 2'b11 && !bus_we_o, "R7 prefetch lanes/we",
                    {29'h0, bus_we_o, bus_bsel_o}, 32'h3);
            end else begin
                a = a0 + 32'(2 * k);
                chk(bus_addr_o == a, (k == 0) ? "R1 first address" : "R2 address step",
                    bus_addr_o, a);
                chk(bus_bsel_o == (a[0] ? 2'b01 : 2'b10), "R2 lane select",
                    32'(bus_bsel_o), a[0] ? 32'h1 : 32'h2);
                chk(bus_we_o == wr, "R4 write enable", 32'(bus_we_o), 32'(wr));
                if (wr) begin
                    eb = src[8*(nb-1-k) +: 8];
                    chk(bus_wdata_o == eb, "R4 byte order", 32'(bus_wdata_o), 32'(eb));
                end
            end
            for (int w = 0; w < dly; w++) begin
                automatic logic [31:0] ha = bus_addr_o;
                automatic logic [7:0]  hd = bus_wdata_o;
                @(negedge clk);
                chk(bus_req_o && bus_addr_o == ha && bus_wdata_o == hd &&
                    bus_prefetch_o == pre, "R8 hold without ack", bus_addr_o, ha);
            end
            bus_ack_i = 1'b1;
            bus_rdata_i = mbyte(bus_addr_o);
            if (!pre && !wr) exp_rd[8*(nb-1-k) +: 8] = mbyte(bus_addr_o);
            if (stray && c == 1) begin
                start_i = 1'b1; to_mem_i = ~wr; size_long_i = ~lng;
                base_i = 32'h0000_0100; disp_i = 16'h0040;
            end
            @(negedge clk);
            bus_ack_i = 1'b0;
            start_i = 1'b0;
        end
        chk(done_o == 1'b1, "R9 done after trailing prefetch", 32'(done_o), 32'h1);
        chk(busy_o == 1'b0 && bus_req_o == 1'b0, "R9 R10 idle at done",
            {30'h0, busy_o, bus_req_o}, 32'h0);
        if (!wr) chk(rdata_o == exp_rd, lng ? "R5 long read assembly" : "R6 word read assembly",
                     rdata_o, exp_rd);
        @(negedge clk);
        chk(done_o == 1'b0 && bus_req_o == 1'b0, "R9 single done pulse / R10 stray start ignored",
            {30'h0, done_o, bus_req_o}, 32'h0);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] bases [5];
        logic [15:0] disps [5];
        bases[0] = 32'h0000_1000; disps[0] = 16'hFFFE;
        bases[1] = 32'h0000_1000; disps[1] = 16'h0010;
        bases[2] = 32'h0000_2001; disps[2] = 16'h0003;
        bases[3] = 32'hFFFF_FFFC; disps[3] = 16'h0008;
        bases[4] = 32'h0000_8000; disps[4] = 16'h8000;
        repeat (3) @(negedge clk);
        chk(bus_req_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0, "R11 reset state",
            {29'h0, bus_req_o, busy_o, done_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_req_o == 1'b0 && busy_o == 1'b0, "R11 idle after reset",
            {30'h0, bus_req_o, busy_o}, 32'h0);
        for (int i = 0; i < 5; i++) begin
            for (int m = 0; m < 4; m++) begin
                automatic bit wr = m[0];
                automatic bit lg = m[1];
                automatic logic [31:0] s = 32'h8C1D_E2F5 ^ (32'h1111_1111 * i);
                automatic logic [31:0] d = 32'hBEEF_0000 | 32'(i * 16 + m);
                run_xfer(wr, lg, bases[i], disps[i], s, d, i + m, (i + m) % 2 == 1);
            end
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule